// File: doc/BRIEF.md
# Prescaled Set/Reset PWM Timer

This block produces a pulse-width-modulated output from a 16-bit up-counter. The counter advances once per enable pulse from a clock-enable prescaler. The prescaler divides the base clock by one of seven powers of two. Two compare values shape the waveform: a match on the set value drives an internal output flip-flop high, and a match on the clear value drives it low and wraps the counter. The waveform period is fixed by the clear value, and the duty cycle by the distance between the two values.

The pin polarity is chosen by an active-level input. Each compare match also raises its own single-cycle strobe, for use as an interrupt source. The timer runs only while it is enabled and the mode input selects general-purpose operation (mode bit low). Otherwise the counter, the prescaler and the flip-flop are held at their idle values, and the next run starts afresh.

Top module: `pwm_sr_timer`

## Requirements
- R1: After reset, the flip-flop is low, so `pwm_o` is at its inactive level, and both strobes are 0.
- R2: `div_sel` values 0 to 6 make the counter advance once every 2^(div_sel+1) base-clock cycles. The value 7 behaves like 6 (divide by 128). The first advance comes 2^(div_sel+1) cycles after the timer starts running.
- R3: The counter counts 0, 1, …, `cmp_clr`, then returns to 0 on the next advance. `clr_irq` therefore pulses once every (`cmp_clr`+1)·2^(div_sel+1) cycles.
- R4: An advance taken while the count equals `cmp_set` sets the flip-flop. The new state is visible on `pwm_o` one clock later.
- R5: An advance taken while the count equals `cmp_clr` resets the flip-flop, with the same one-clock latency as R4.
- R6: `set_irq` and `clr_irq` are one-cycle pulses. They rise in the same cycle that the flip-flop takes the matching new state.
- R7: When `cmp_set` equals `cmp_clr`, the reset wins: the flip-flop stays low, and both strobes pulse together.
- R8: While `run_en` is 0 or `mode_sel` is 1, the counter, the prescaler phase and the flip-flop are forced to 0 from the next clock, and no strobe is raised.
- R9: With `act_hi`=1, `pwm_o` equals the flip-flop state. With `act_hi`=0, `pwm_o` is its inverse. A change of `act_hi` reaches `pwm_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | 0 = general-purpose timer mode (runs); 1 = other mode (held idle) |
| run_en | input | 1 | Count enable |
| div_sel | input | 3 | Prescaler select, division 2^(div_sel+1), 7 treated as 6 |
| cmp_set | input | 16 | Compare value that sets the output flip-flop |
| cmp_clr | input | 16 | Compare value that resets the flip-flop and wraps the counter |
| act_hi | input | 1 | 1 = pin high when flip-flop set; 0 = pin low when set |
| pwm_o | output | 1 | PWM pin |
| set_irq | output | 1 | Strobe on a set-value match |
| clr_irq | output | 1 | Strobe on a clear-value match |

## Verification
A match is decided at the clock edge on which the prescaler advance occurs. The strobes and the flip-flop change together just after that edge, so one cycle after the count condition holds. The bench computes those cycles with its own model of the prescaler phase and the counter. It compares the outputs at every falling edge, after the outputs have settled and before any input changes.

The polarity input acts combinationally and is checked in the same cycle it is driven. Disabling the timer is checked from the following cycle. The period checks count the cycles between successive clear strobes and compare them with (`cmp_clr`+1)·2^(div_sel+1).

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int CNT_W_DEF = 16;
    localparam int SEL_W_DEF = 3;
    localparam int DIV_W_DEF = 7;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int SEL_W = pwm_pkg::SEL_W_DEF,
    parameter int DIV_W = pwm_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int MAX_SEL = DIV_W - 1;

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } tg_state_t;

    tg_state_t st_d, st_q;
    logic [SEL_W-1:0] sel_eff;
    logic [DIV_W:0]   mask_wide;
    logic [DIV_W-1:0] mask;

    always_comb begin
        sel_eff   = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
        mask_wide = ({{DIV_W{1'b0}}, 1'b1} << (int'(sel_eff) + 1)) - 1'b1;
        mask      = mask_wide[DIV_W-1:0];
        tick      = run && ((st_q.phase & mask) == mask);
        st_d      = st_q;
        if (!run) st_d.phase = '0;
        else      st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_count_cmp.sv
module pwm_count_cmp #(
    parameter int CNT_W = pwm_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_set,
    input  logic [CNT_W-1:0] cmp_clr,
    output logic             hit_set,
    output logic             hit_clr
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cc_state_t;

    cc_state_t st_d, st_q;

    always_comb begin
        hit_set = tick && (st_q.cnt == cmp_set);
        hit_clr = tick && (st_q.cnt == cmp_clr);
        st_d    = st_q;
        if (!run)         st_d.cnt = '0;
        else if (hit_clr) st_d.cnt = '0;
        else if (tick)    st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_sr_out.sv
module pwm_sr_out (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hit_set,
    input  logic hit_clr,
    input  logic act_hi,
    output logic pwm_o,
    output logic set_irq,
    output logic clr_irq
);
    typedef struct packed {
        logic ff;
        logic s_stb;
        logic r_stb;
    } so_state_t;

    so_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.s_stb = run && hit_set;
        st_d.r_stb = run && hit_clr;
        if (!run)         st_d.ff = 1'b0;
        else if (hit_clr) st_d.ff = 1'b0;   // reset dominates
        else if (hit_set) st_d.ff = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o   = act_hi ? st_q.ff : ~st_q.ff;
    assign set_irq = st_q.s_stb;
    assign clr_irq = st_q.r_stb;
endmodule

// File: rtl/pwm_sr_timer.sv
module pwm_sr_timer #(
    parameter int CNT_W = pwm_pkg::CNT_W_DEF,
    parameter int SEL_W = pwm_pkg::SEL_W_DEF,
    parameter int DIV_W = pwm_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic             run_en,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [CNT_W-1:0] cmp_set,
    input  logic [CNT_W-1:0] cmp_clr,
    input  logic             act_hi,
    output logic             pwm_o,
    output logic             set_irq,
    output logic             clr_irq
);
    logic run, tick, hit_set, hit_clr;

    assign run = run_en && !mode_sel;

    pwm_tick_gen #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(div_sel), .tick(tick)
    );

    pwm_count_cmp #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .cmp_set(cmp_set), .cmp_clr(cmp_clr),
        .hit_set(hit_set), .hit_clr(hit_clr)
    );

    pwm_sr_out u_out (
        .clk(clk), .rst_n(rst_n), .run(run), .hit_set(hit_set), .hit_clr(hit_clr),
        .act_hi(act_hi), .pwm_o(pwm_o), .set_irq(set_irq), .clr_irq(clr_irq)
    );
endmodule

// File: rtl/pwm_sr_timer_chk.sv
module pwm_sr_timer_chk #(
    parameter int CNT_W = pwm_pkg::CNT_W_DEF,
    parameter int SEL_W = pwm_pkg::SEL_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_sel,
    input logic             run_en,
    input logic [SEL_W-1:0] div_sel,
    input logic [CNT_W-1:0] cmp_set,
    input logic [CNT_W-1:0] cmp_clr,
    input logic             act_hi,
    input logic             pwm_o,
    input logic             set_irq,
    input logic             clr_irq
);
    assert_set_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_irq |=> !set_irq);

    assert_clr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_irq |=> !clr_irq);

    assert_clr_inactive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_irq |-> (pwm_o != act_hi));

    assert_set_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_irq && !clr_irq) |-> (pwm_o == act_hi));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel || !run_en) |=> (!set_irq && !clr_irq && (pwm_o != act_hi)));

    assert_same_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_set == cmp_clr && $stable(cmp_set) && $stable(cmp_clr) && set_irq) |-> clr_irq);
endmodule

bind pwm_sr_timer pwm_sr_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/sim_pwm_sr_timer.sv
`timescale 1ns/1ps
module sim_pwm_sr_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sel = 1'b0, run_en = 1'b0, act_hi = 1'b1;
    logic [2:0]  div_sel = 3'd0;
    logic [15:0] cmp_set = 16'd0, cmp_clr = 16'd0;
    logic        pwm_o, set_irq, clr_irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference model state
    int unsigned m_phase = 0;
    int unsigned m_cnt = 0;
    bit m_ff = 0, m_s = 0, m_r = 0;

    always #5 clk = ~clk;

    pwm_sr_timer u0 (.*);

    function automatic int unsigned div_of(input logic [2:0] s);
        return (s > 3'd6) ? 128 : (2 << s);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || !run_en || mode_sel) begin
            m_phase = 0; m_cnt = 0; m_ff = 0; m_s = 0; m_r = 0;
        end else begin
            int unsigned n;
            bit tk;
            n  = div_of(div_sel);
            tk = (m_phase % n) == n - 1;
            m_phase = m_phase + 1;
            m_s = tk && (m_cnt == cmp_set);
            m_r = tk && (m_cnt == cmp_clr);
            if (tk) begin
                if (m_r) m_ff = 0;
                else if (m_s) m_ff = 1;
                m_cnt = (m_cnt == cmp_clr) ? 0 : m_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // compare all outputs with the model at the falling edge, then advance
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R4/R5/R9 pwm_o", pwm_o, act_hi ? m_ff : !m_ff);
            chk("R6 set_irq", set_irq, m_s);
            chk("R6/R3 clr_irq", clr_irq, m_r);
        end
    endtask

    task automatic measure_period(input logic [2:0] s, input int c, input string tag);
        int gap;
        @(negedge clk);
        run_en = 0; div_sel = s; cmp_clr = 16'(c); cmp_set = 16'(c / 2);
        @(negedge clk);
        run_en = 1;
        gap = 0;
        while (!clr_irq && gap < 20000) begin @(negedge clk); gap++; end
        gap = 0;
        @(negedge clk);
        gap = 1;
        while (!clr_irq && gap < 20000) begin @(negedge clk); gap++; end
        checks++;
        if (gap != (c + 1) * div_of(s)) begin
            fails++;
            $display("FAIL %s period: got %0d expected %0d", tag, gap, (c + 1) * div_of(s));
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        #12;
        chk("R1 pwm_o", pwm_o, 1'b0);
        chk("R1 set_irq", set_irq, 1'b0);
        chk("R1 clr_irq", clr_irq, 1'b0);
        @(negedge clk); rst_n = 1;
        step(4);

        // R2/R3: period by strobe spacing
        measure_period(3'd0, 5, "R2 R3 div2");
        measure_period(3'd1, 9, "R2 R3 div4");
        measure_period(3'd7, 3, "R2 div sel7 as 128");

        // R7: equal compares keep output inactive
        @(negedge clk);
        run_en = 0; div_sel = 3'd0; cmp_set = 16'd5; cmp_clr = 16'd5; act_hi = 1;
        @(negedge clk); run_en = 1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            chk("R7 pwm_o inactive", pwm_o, 1'b0);
            chk("R7 strobes together", set_irq, clr_irq);
        end

        // R4/R5/R9: directed waveform against the model, both polarities
        cmp_set = 16'd2; cmp_clr = 16'd6; act_hi = 1;
        step(80);
        act_hi = 0;
        step(80);

        // R8: mode bit forces idle
        mode_sel = 1;
        @(negedge clk);
        step(1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R8 idle set_irq", set_irq, 1'b0);
            chk("R8 idle pwm", pwm_o, 1'b1);
        end
        mode_sel = 0;
        step(40);

        // constrained random segments
        for (int seg = 0; seg < 40; seg++) begin
            div_sel = 3'($urandom_range(0, 7));
            cmp_clr = 16'($urandom_range(0, 30));
            cmp_set = 16'($urandom_range(0, 34));
            act_hi  = 1'($urandom_range(0, 1));
            run_en  = ($urandom_range(0, 5) != 0);
            mode_sel = ($urandom_range(0, 7) == 0);
            step($urandom_range(40, 600));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule